// File: doc/BRIEF.md
# One-Write Two-Read Register File

This block is a small flip-flop register file of 64 words, 4 bits each. One write port stores a word on the rising clock edge. Two read ports run at the same time and each has its own 6-bit address, its own output enable and its own data output. Any pair of locations can be read at once, and both ports may point at the same word.

The write address and the two read addresses each go through their own 6-to-64 one-hot decoder. The write data bus reaches every word. A word loads it only when its decoder line is high and the write control is high. Reads are combinational: the selected word is gathered by an AND-OR tree driven by that port's decoder.

Each word has a "written since reset" flag. Stored data is not reset. A port reports valid only when its enable is high and the addressed word has been written. In every other case the port drives zero, so an output never shows undefined data.

Top module: `rf1w2r_top`

## Requirements
- R1: While reset is low at a rising edge, all written flags clear. After reset, every enabled read returns valid=0 and data=0 until that word is written.
- R2: With wr_en=1 at a rising edge, wr_data is stored at wr_addr. From the next cycle, an enabled read of that address returns that data with valid=1.
- R3: With wr_en=0 at a rising edge, no word and no written flag changes, whatever wr_addr and wr_data hold.
- R4: A write changes only the word at wr_addr. Every other word keeps its value.
- R5: Reads are combinational. A read of the address being written in the same cycle returns the old contents until the edge that completes the write.
- R6: When a port's output enable is 0, that port drives data=0 and valid=0. The other port is not affected.
- R7: Both ports read independently in the same cycle. When both address the same word, they return identical data and valid.
- R8: A read of a word not written since reset returns valid=0 and data=0, even with the enable at 1.
- R9: Writing 4'b1011, 4'b0100, 4'b1001 and 4'b0010 to addresses 0, 21, 42 and 63, then reading those addresses on both ports, returns the same values on both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears written flags |
| wr_en | input | 1 | Write control, 1 = write on this edge |
| wr_addr | input | 6 | Write address |
| wr_data | input | 4 | Write data |
| rd0_oe | input | 1 | Read port 0 output enable |
| rd0_addr | input | 6 | Read port 0 address |
| rd0_data | output | 4 | Read port 0 data, 0 when disabled or unwritten |
| rd0_valid | output | 1 | Read port 0 valid flag |
| rd1_oe | input | 1 | Read port 1 output enable |
| rd1_addr | input | 6 | Read port 1 address |
| rd1_data | output | 4 | Read port 1 data, 0 when disabled or unwritten |
| rd1_valid | output | 1 | Read port 1 valid flag |

## Verification
The assertions check several properties on every cycle. A write lands in the addressed word on the next cycle. The array and its flags hold still when wr_en is low. The write decode has exactly one line high. Written flags never fall outside reset. A disabled port stays at zero. The two ports agree whenever they share an address. Other behaviour needs the bench's stimulus and a reference array: that reads see pre-write data in the cycle of the write, the fixed four-address pattern, reads of unwritten words, and long random mixes of writes and concurrent reads on both ports.

// File: rtl/rf1w2r_pkg.sv
// Package: default geometry shared by the register file modules.
// Assumes: depth is always a power of two set by the address width.
package rf1w2r_pkg;
    localparam int RF_ADDR_W = 6;
    localparam int RF_DATA_W = 4;
    localparam int RF_DEPTH  = 1 << RF_ADDR_W;
endpackage

// File: rtl/rf_onehot_dec.sv
// Module: binary to one-hot address decoder.
// Assumes: DEPTH equals 2**ADDR_W, so exactly one output is high for any address.
module rf_onehot_dec #(
    parameter int ADDR_W = rf1w2r_pkg::RF_ADDR_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  hot
);
    // One comparator per decoded line.
    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        assign hot[g] = (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/rf_word_array.sv
// Module: flip-flop storage words plus per-word written flags.
// Assumes: wr_hot is a one-hot decode; data words have no reset, flags do.
module rf_word_array #(
    parameter int ADDR_W = rf1w2r_pkg::RF_ADDR_W,
    parameter int DATA_W = rf1w2r_pkg::RF_DATA_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DEPTH-1:0]              wr_hot,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DEPTH-1:0][DATA_W-1:0]  words_q,
    output logic [DEPTH-1:0]              written_q
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Load this word when its decode line and the write control agree.
        always_ff @(posedge clk) begin
            if (wr_en && wr_hot[g]) begin
                words_q[g] <= wr_data;
            end
        end

        // Track whether this word has been written since reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                written_q[g] <= 1'b0;
            end else if (wr_en && wr_hot[g]) begin
                written_q[g] <= 1'b1;
            end
        end
    end

    // R4: the write decode selects exactly one word.
    assert_dec_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_hot) == 1);

    // R8: a written flag only falls through reset.
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((written_q & $past(written_q)) == $past(written_q)));
endmodule

// File: rtl/rf_read_port.sv
// Module: one read port with its own decoder, AND-OR select and output gate.
// Assumes: the words and flags come straight from the storage array.
module rf_read_port #(
    parameter int ADDR_W = rf1w2r_pkg::RF_ADDR_W,
    parameter int DATA_W = rf1w2r_pkg::RF_DATA_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          oe,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  words_q,
    input  logic [DEPTH-1:0]              written_q,
    output logic [DATA_W-1:0]             data,
    output logic                          valid
);
    logic [DEPTH-1:0]  rd_hot;
    logic [DATA_W-1:0] sel_data;
    logic              sel_hit;

    rf_onehot_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .hot  (rd_hot)
    );

    // Gather the selected word and its flag through an AND-OR tree.
    always_comb begin
        sel_data = '0;
        sel_hit  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            sel_data = sel_data | (words_q[i] & {DATA_W{rd_hot[i]}});
            sel_hit  = sel_hit | (rd_hot[i] & written_q[i]);
        end
    end

    // Drive the port only when enabled and the word holds written data.
    always_comb begin
        valid = oe && sel_hit;
        data  = valid ? sel_data : '0;
    end

    // R6: a disabled port stays quiet.
    assert_port_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (data == '0 && !valid));
endmodule

// File: rtl/rf1w2r_top.sv
// Module: 64x4 register file, one write port and two independent read ports.
// Assumes: synchronous active-low reset; reads are combinational.
module rf1w2r_top #(
    parameter int ADDR_W = rf1w2r_pkg::RF_ADDR_W,
    parameter int DATA_W = rf1w2r_pkg::RF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd0_oe,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_valid,
    input  logic              rd1_oe,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]             wr_hot;
    logic [DEPTH-1:0][DATA_W-1:0] words_q;
    logic [DEPTH-1:0]             written_q;

    rf_onehot_dec #(.ADDR_W(ADDR_W)) u_wr_dec (
        .addr (wr_addr),
        .hot  (wr_hot)
    );

    rf_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_hot    (wr_hot),
        .wr_data   (wr_data),
        .words_q   (words_q),
        .written_q (written_q)
    );

    rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe        (rd0_oe),
        .addr      (rd0_addr),
        .words_q   (words_q),
        .written_q (written_q),
        .data      (rd0_data),
        .valid     (rd0_valid)
    );

    rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe        (rd1_oe),
        .addr      (rd1_addr),
        .words_q   (words_q),
        .written_q (written_q),
        .data      (rd1_data),
        .valid     (rd1_valid)
    );

    // R2: a write is present in the addressed word on the next cycle.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (words_q[$past(wr_addr)] == $past(wr_data)) && written_q[$past(wr_addr)]);

    // R3: with no write, the array and its flags hold.
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(words_q) && $stable(written_q)));

    // R7: both ports agree on a shared enabled address.
    assert_ports_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_oe && rd1_oe && rd0_addr == rd1_addr) |->
            (rd0_data == rd1_data && rd0_valid == rd1_valid));
endmodule

// File: tb/rf1w2r_top_tb.sv
// Bench: scoreboard of expected port results against a reference array.
module rf1w2r_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       rd0_oe = 1'b0;
    logic [5:0] rd0_addr = '0;
    logic [3:0] rd0_data;
    logic       rd0_valid;
    logic       rd1_oe = 1'b0;
    logic [5:0] rd1_addr = '0;
    logic [3:0] rd1_data;
    logic       rd1_valid;

    always #2 clk = ~clk;

    rf1w2r_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_oe(rd0_oe), .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd0_valid(rd0_valid),
        .rd1_oe(rd1_oe), .rd1_addr(rd1_addr), .rd1_data(rd1_data), .rd1_valid(rd1_valid)
    );

    typedef struct {
        string    req;
        int       port;
        logic [3:0] d;
        logic     v;
    } exp_t;

    exp_t       sb_q[$];
    logic [3:0] ref_mem [64];
    logic       ref_vld [64];
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    // Monitor: pop this cycle's expectations and compare at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            logic [3:0] ad;
            logic       av;
            e  = sb_q.pop_front();
            ad = (e.port == 0) ? rd0_data : rd1_data;
            av = (e.port == 0) ? rd0_valid : rd1_valid;
            checks++;
            if (ad !== e.d || av !== e.v) begin
                errors++;
                $display("FAIL %s port%0d: actual data=%b valid=%b expected data=%b valid=%b",
                         e.req, e.port, ad, av, e.d, e.v);
            end
        end
    end

    function automatic exp_t expect_port(string req, int port, logic oe, logic [5:0] a);
        exp_t e;
        e.req  = req;
        e.port = port;
        e.v    = oe && ref_vld[a];
        e.d    = e.v ? ref_mem[a] : 4'b0000;
        return e;
    endfunction

    // Driver: apply one cycle, push expected results, then update the model.
    task automatic step(string req, logic we, logic [5:0] wa, logic [3:0] wd,
                        logic oe0, logic [5:0] a0, logic oe1, logic [5:0] a1);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd0_oe = oe0; rd0_addr = a0; rd1_oe = oe1; rd1_addr = a1;
        sb_q.push_back(expect_port(req, 0, oe0, a0));
        sb_q.push_back(expect_port(req, 1, oe1, a1));
        @(posedge clk);
        if (we) begin
            ref_mem[wa] = wd;
            ref_vld[wa] = 1'b1;
        end
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=still running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            ref_mem[i] = 4'b0000;
            ref_vld[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: after reset both ports read nothing valid.
        step("R1", 0, 0, 0, 1, 6'd0, 1, 6'd63);
        // R8: unwritten word stays invalid with the enable on.
        step("R8", 0, 0, 0, 1, 6'd10, 1, 6'd11);

        // R9: fixed pattern, then both ports read each address.
        step("R9", 1, 6'd0,  4'b1011, 0, 0, 0, 0);
        step("R9", 1, 6'd21, 4'b0100, 0, 0, 0, 0);
        step("R9", 1, 6'd42, 4'b1001, 0, 0, 0, 0);
        step("R9", 1, 6'd63, 4'b0010, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 6'd0,  1, 6'd0);
        step("R9", 0, 0, 0, 1, 6'd21, 1, 6'd21);
        step("R9", 0, 0, 0, 1, 6'd42, 1, 6'd42);
        step("R9", 0, 0, 0, 1, 6'd63, 1, 6'd63);

        // R5: read the word under write sees old data, then new.
        step("R5", 1, 6'd21, 4'b1110, 1, 6'd21, 1, 6'd42);
        step("R5", 0, 0, 0, 1, 6'd21, 1, 6'd21);

        // R3: write control low leaves the word alone.
        step("R3", 0, 6'd42, 4'b0111, 1, 6'd42, 1, 6'd0);
        step("R3", 0, 0, 0, 1, 6'd42, 1, 6'd42);

        // R4: writing a neighbour leaves adjacent words unchanged.
        step("R4", 1, 6'd1, 4'b0110, 1, 6'd0, 0, 0);
        step("R4", 0, 0, 0, 1, 6'd0, 1, 6'd2);

        // R2: fresh write visible the next cycle.
        step("R2", 1, 6'd30, 4'b1100, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 1, 6'd30, 1, 6'd1);

        // R6: one port disabled, the other still reads.
        step("R6", 0, 0, 0, 0, 6'd30, 1, 6'd30);
        step("R6", 0, 0, 0, 1, 6'd63, 0, 6'd63);

        // R7: two ports on different and same addresses at once.
        step("R7", 0, 0, 0, 1, 6'd0, 1, 6'd63);
        step("R7", 0, 0, 0, 1, 6'd1, 1, 6'd1);

        // Initialise every location before the random mix.
        for (int i = 0; i < 64; i++) begin
            step("R2", 1, 6'(i), 4'(i * 7 + 3), 0, 0, 0, 0);
        end

        // R7: random writes with concurrent reads on both ports.
        for (int n = 0; n < 400; n++) begin
            logic [5:0] a0;
            logic [5:0] a1;
            a0 = 6'($urandom);
            a1 = ($urandom % 4 == 0) ? a0 : 6'($urandom);
            step("R7", 1'($urandom), 6'($urandom), 4'($urandom),
                 ($urandom % 5) != 0, a0, ($urandom % 5) != 0, a1);
        end

        @(negedge clk);
        #1;
        done = 1;
        summary();
        $finish;
    end
endmodule